// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block sits behind a byte-wide host link and turns a stream of command bytes into accesses on a small internal register file. Every command byte holds an opcode in its upper nibble and a four-bit payload in its lower nibble. A register address is built from two nibble commands, one for each half. A write needs two data commands: the first latches the low half of the byte. The second supplies the high half and stores the whole byte at once.

Read commands copy the addressed byte into a one-deep output stream. The read-with-increment variant then steps the address, but only inside the current block of sixteen registers. A host can therefore fetch a run of neighbouring registers without resending the address.

The register file holds four kinds of register:
- an identification byte, which is read-only;
- a scratch byte that checks the link by echoing back whatever was written;
- a mode byte, whose initialisation bit fires a single-cycle request toward the memory controller;
- a run of seven read-only bytes that report capture positions and status.

Top module: `nibcmd_regif`

## Requirements
- R1: After a synchronous active-high reset, the address is 0x00, the latched data nibble is 0, the scratch and mode registers read 0x00, no read result is pending and the init request is low.
- R2: Command 0x0n sets address bits [3:0] to n, and command 0x1n sets address bits [7:4] to n. Each leaves the other half of the address unchanged.
- R3: Command 0x2n latches n as the low data nibble and changes no register. Command 0x3n stores the byte {n, latched nibble} to the current address on its own acceptance.
- R4: Commands 0x40 (read) and 0x50 (read with increment) present the byte at the current address on the output stream one cycle after the command is accepted. That byte stays valid and unchanged until the output is taken.
- R5: After a 0x50 read, address bits [3:0] step up by one and wrap from 0xF to 0x0, with no carry into bits [7:4]. A 0x40 read leaves the address unchanged.
- R6: The scratch register at address 0x01 returns any of the 256 byte values exactly as written.
- R7: The identification register at address 0x00 always reads 0xA5. Writes to it and to the position block are ignored.
- R8: Addresses 0x10 to 0x16 read, in order, the trigger position bytes 0 (least significant) to 2, then the stop position bytes 0 to 2, then the capture status byte.
- R9: Writing the mode register at address 0x02 with bit 0 set drives the init request high for exactly one cycle. The mode register reads back the written byte with bit 0 cleared. A write with bit 0 clear raises no request.
- R10: While a read result waits to be taken, the command input is not ready and accepts no command.
- R11: Command bytes with an upper nibble of 0x6 to 0xF change no state and produce no output byte.
- R12: Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | A command byte is offered |
| cmd_ready_o | output | 1 | The decoder accepts the offered byte |
| cmd_byte_i | input | 8 | Command byte: opcode [7:4], payload [3:0] |
| rd_valid_o | output | 1 | A read result is available |
| rd_ready_i | input | 1 | The consumer takes the read result |
| rd_byte_o | output | 8 | Read result byte |
| trig_pos_i | input | 24 | Trigger position from the capture logic |
| stop_pos_i | input | 24 | Stop position from the capture logic |
| cap_status_i | input | 8 | Capture status byte |
| sdram_init_o | output | 1 | Single-cycle memory initialisation request |

## Verification
The timing of each effect depends on the edge at which a command is accepted:
- An address or data command takes effect at that edge.
- A committed write can be seen by any read accepted after it.
- A read result is sampled half a cycle after the first following edge, which is when it becomes valid.
- The init pulse also appears after the accept edge of the committing command, and it is counted over the whole window that follows.

The bench drives inputs and samples outputs on falling edges, so every comparison falls in the cycle in which its result is due. Its sweeps cover every scratch value, every opcode in the unused range and the wrap at the end of an address block.

// File: rtl/nibcmd_pkg.sv
`timescale 1ns/1ps
package nibcmd_pkg;
   localparam int NIB_W  = 4;
   localparam int BYTE_W = 2 * NIB_W;

   typedef enum logic [NIB_W-1:0] {
      OP_ADDR_LO  = 4'h0,
      OP_ADDR_HI  = 4'h1,
      OP_DATA_LO  = 4'h2,
      OP_DATA_WR  = 4'h3,
      OP_READ     = 4'h4,
      OP_READ_INC = 4'h5
   } opcode_e;

   typedef struct packed {
      logic set_lo;
      logic set_hi;
      logic dat_lo;
      logic commit;
      logic rd;
      logic rd_inc;
   } dec_t;
endpackage

// File: rtl/nibcmd_decode.sv
`timescale 1ns/1ps
module nibcmd_decode
   import nibcmd_pkg::*;
(
   input  logic              fire,
   input  logic [BYTE_W-1:0] cmd_byte,
   output dec_t              dec,
   output logic [NIB_W-1:0]  payload
);
   logic [NIB_W-1:0] op;

   assign op      = cmd_byte[BYTE_W-1:NIB_W];
   assign payload = cmd_byte[NIB_W-1:0];

   always_comb begin
      dec = '0;
      if (fire) begin
         case (op)
            OP_ADDR_LO:  dec.set_lo = 1'b1;
            OP_ADDR_HI:  dec.set_hi = 1'b1;
            OP_DATA_LO:  dec.dat_lo = 1'b1;
            OP_DATA_WR:  dec.commit = 1'b1;
            OP_READ:     dec.rd     = 1'b1;
            OP_READ_INC: begin
               dec.rd     = 1'b1;
               dec.rd_inc = 1'b1;
            end
            default:     dec = '0;
         endcase
      end
   end
endmodule

// File: rtl/nibcmd_assemble.sv
`timescale 1ns/1ps
module nibcmd_assemble
   import nibcmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  dec_t              dec,
   input  logic [NIB_W-1:0]  payload,
   output logic [BYTE_W-1:0] addr,
   output logic [BYTE_W-1:0] wdata,
   output logic              wr_en
);
   logic [NIB_W-1:0] a_lo_q, a_hi_q, d_lo_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_lo_q <= '0;
         a_hi_q <= '0;
         d_lo_q <= '0;
      end else begin
         if (dec.set_lo)
            a_lo_q <= payload;
         else if (dec.rd_inc)
            a_lo_q <= a_lo_q + 1'b1;
         if (dec.set_hi)
            a_hi_q <= payload;
         if (dec.dat_lo)
            d_lo_q <= payload;
      end
   end

   assign addr  = {a_hi_q, a_lo_q};
   assign wdata = {payload, d_lo_q};
   assign wr_en = dec.commit;
endmodule

// File: rtl/nibcmd_regbank.sv
`timescale 1ns/1ps
module nibcmd_regbank
   import nibcmd_pkg::*;
#(
   parameter logic [7:0] ID_VALUE  = 8'hA5,
   parameter logic [7:0] ID_ADDR   = 8'h00,
   parameter logic [7:0] TEST_ADDR = 8'h01,
   parameter logic [7:0] MODE_ADDR = 8'h02,
   parameter logic [7:0] POS_BASE  = 8'h10,
   parameter int         POS_W     = 24,
   parameter int         INIT_BIT  = 0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              wr_en,
   input  logic [POS_W-1:0]  trig_pos,
   input  logic [POS_W-1:0]  stop_pos,
   input  logic [BYTE_W-1:0] status,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              init_pulse
);
   localparam int POS_NB    = POS_W / BYTE_W;
   localparam int POS_BYTES = 2 * POS_NB + 1;
   localparam int IDX_W     = $clog2(POS_BYTES);

   logic [BYTE_W-1:0] test_q, mode_q;
   logic [BYTE_W-1:0] pos_bytes [POS_BYTES];
   logic [BYTE_W-1:0] off;

   for (genvar g = 0; g < POS_NB; g++) begin : g_pos
      assign pos_bytes[g]          = trig_pos[g*BYTE_W +: BYTE_W];
      assign pos_bytes[g + POS_NB] = stop_pos[g*BYTE_W +: BYTE_W];
   end
   assign pos_bytes[POS_BYTES-1] = status;

   always_ff @(posedge clk) begin
      if (rst) begin
         test_q     <= '0;
         mode_q     <= '0;
         init_pulse <= 1'b0;
      end else begin
         init_pulse <= 1'b0;
         if (wr_en && addr == TEST_ADDR)
            test_q <= wdata;
         if (wr_en && addr == MODE_ADDR) begin
            mode_q           <= wdata;
            mode_q[INIT_BIT] <= 1'b0;
            init_pulse       <= wdata[INIT_BIT];
         end
      end
   end

   assign off = addr - POS_BASE;

   always_comb begin
      rd_byte = '0;
      if (addr == ID_ADDR)
         rd_byte = ID_VALUE;
      else if (addr == TEST_ADDR)
         rd_byte = test_q;
      else if (addr == MODE_ADDR)
         rd_byte = mode_q;
      else if (off < 8'(POS_BYTES))
         rd_byte = pos_bytes[off[IDX_W-1:0]];
   end
endmodule

// File: rtl/nibcmd_rdbuf.sv
`timescale 1ns/1ps
module nibcmd_rdbuf
   import nibcmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [BYTE_W-1:0] din,
   input  logic              take,
   output logic              valid,
   output logic [BYTE_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (take) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/nibcmd_regif.sv
`timescale 1ns/1ps
module nibcmd_regif
   import nibcmd_pkg::*;
#(
   parameter logic [7:0] ID_VALUE  = 8'hA5,
   parameter logic [7:0] ID_ADDR   = 8'h00,
   parameter logic [7:0] TEST_ADDR = 8'h01,
   parameter logic [7:0] MODE_ADDR = 8'h02,
   parameter logic [7:0] POS_BASE  = 8'h10,
   parameter int         POS_W     = 24,
   parameter int         INIT_BIT  = 0
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         cmd_valid_i,
   output logic         cmd_ready_o,
   input  logic [7:0]   cmd_byte_i,
   output logic         rd_valid_o,
   input  logic         rd_ready_i,
   output logic [7:0]   rd_byte_o,
   input  logic [23:0]  trig_pos_i,
   input  logic [23:0]  stop_pos_i,
   input  logic [7:0]   cap_status_i,
   output logic         sdram_init_o
);
   localparam int POS_BYTES = 2 * (POS_W / BYTE_W) + 1;

   if (POS_W % BYTE_W != 0)
      $error("POS_W must be a whole number of bytes");
   if (POS_W != 24)
      $error("position ports are 24 bits wide");
   if (INIT_BIT < 0 || INIT_BIT >= BYTE_W)
      $error("INIT_BIT outside the mode byte");
   if (32'(POS_BASE[3:0]) + POS_BYTES > 16)
      $error("position block must fit in one 16-register window");
   if (ID_ADDR == TEST_ADDR || ID_ADDR == MODE_ADDR || TEST_ADDR == MODE_ADDR)
      $error("register addresses must differ");

   dec_t              dec;
   logic [NIB_W-1:0]  payload;
   logic [BYTE_W-1:0] addr, wdata, rd_byte;
   logic              wr_en, fire;

   assign cmd_ready_o = ~rd_valid_o;
   assign fire        = cmd_valid_i & cmd_ready_o;

   nibcmd_decode u_dec (
      .fire     (fire),
      .cmd_byte (cmd_byte_i),
      .dec      (dec),
      .payload  (payload)
   );

   nibcmd_assemble u_asm (
      .clk     (clk),
      .rst     (rst),
      .dec     (dec),
      .payload (payload),
      .addr    (addr),
      .wdata   (wdata),
      .wr_en   (wr_en)
   );

   nibcmd_regbank #(
      .ID_VALUE  (ID_VALUE),
      .ID_ADDR   (ID_ADDR),
      .TEST_ADDR (TEST_ADDR),
      .MODE_ADDR (MODE_ADDR),
      .POS_BASE  (POS_BASE),
      .POS_W     (POS_W),
      .INIT_BIT  (INIT_BIT)
   ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .addr       (addr),
      .wdata      (wdata),
      .wr_en      (wr_en),
      .trig_pos   (trig_pos_i),
      .stop_pos   (stop_pos_i),
      .status     (cap_status_i),
      .rd_byte    (rd_byte),
      .init_pulse (sdram_init_o)
   );

   nibcmd_rdbuf u_rbuf (
      .clk   (clk),
      .rst   (rst),
      .load  (dec.rd),
      .din   (rd_byte),
      .take  (rd_ready_i),
      .valid (rd_valid_o),
      .dout  (rd_byte_o)
   );
endmodule

// File: rtl/nibcmd_regif_chk.sv
`timescale 1ns/1ps
module nibcmd_regif_chk (
   input logic       clk,
   input logic       rst,
   input logic       cmd_valid_i,
   input logic       cmd_ready_o,
   input logic [7:0] cmd_byte_i,
   input logic       rd_valid_o,
   input logic       rd_ready_i,
   input logic [7:0] rd_byte_o,
   input logic       sdram_init_o
);
   logic acc;
   assign acc = cmd_valid_i && cmd_ready_o;

   p_stall_r10: assert property (@(posedge clk) disable iff (rst)
      rd_valid_o |-> !cmd_ready_o);

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_byte_o)));

   p_read_due_r4: assert property (@(posedge clk) disable iff (rst)
      (acc && (cmd_byte_i[7:4] == 4'h4 || cmd_byte_i[7:4] == 4'h5)) |=> rd_valid_o);

   p_pulse_len_r9: assert property (@(posedge clk) disable iff (rst)
      sdram_init_o |=> !sdram_init_o);

   p_pulse_src_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(sdram_init_o) |-> $past(acc && cmd_byte_i[7:4] == 4'h3));

   p_unused_op_r11: assert property (@(posedge clk) disable iff (rst)
      (acc && cmd_byte_i[7:4] >= 4'h6) |=> !rd_valid_o);
endmodule

bind nibcmd_regif nibcmd_regif_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .cmd_valid_i  (cmd_valid_i),
   .cmd_ready_o  (cmd_ready_o),
   .cmd_byte_i   (cmd_byte_i),
   .rd_valid_o   (rd_valid_o),
   .rd_ready_i   (rd_ready_i),
   .rd_byte_o    (rd_byte_o),
   .sdram_init_o (sdram_init_o)
);

// File: tb/nibcmd_regif_test.sv
`timescale 1ns/1ps
module nibcmd_regif_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid_i = 1'b0;
   logic        cmd_ready_o;
   logic [7:0]  cmd_byte_i = 8'h00;
   logic        rd_valid_o;
   logic        rd_ready_i = 1'b0;
   logic [7:0]  rd_byte_o;
   logic [23:0] trig_pos_i = 24'h3C_5A_71;
   logic [23:0] stop_pos_i = 24'hE4_92_0B;
   logic [7:0]  cap_status_i = 8'h6D;
   logic        sdram_init_o;

   int vectors = 0;
   int miscompares = 0;
   int pulses = 0;

   always #5 clk = ~clk;

   nibcmd_regif uut (
      .clk          (clk),
      .rst          (rst),
      .cmd_valid_i  (cmd_valid_i),
      .cmd_ready_o  (cmd_ready_o),
      .cmd_byte_i   (cmd_byte_i),
      .rd_valid_o   (rd_valid_o),
      .rd_ready_i   (rd_ready_i),
      .rd_byte_o    (rd_byte_o),
      .trig_pos_i   (trig_pos_i),
      .stop_pos_i   (stop_pos_i),
      .cap_status_i (cap_status_i),
      .sdram_init_o (sdram_init_o)
   );

   always @(posedge clk) if (!rst && sdram_init_o) pulses++;

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      cmd_byte_i  = b;
      cmd_valid_i = 1'b1;
      while (!cmd_ready_o) @(negedge clk);
      @(posedge clk);
      #1 cmd_valid_i = 1'b0;
   endtask

   task automatic set_addr(input logic [7:0] a);
      send({4'h0, a[3:0]});
      send({4'h1, a[7:4]});
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      set_addr(a);
      send({4'h2, d[3:0]});
      send({4'h3, d[7:4]});
   endtask

   task automatic rd(input bit inc, output logic [7:0] v);
      send(inc ? 8'h50 : 8'h40);
      @(negedge clk);
      chk("R4 valid one cycle after read", int'(rd_valid_o), 1);
      v = rd_byte_o;
      rd_ready_i = 1'b1;
      @(posedge clk);
      #1 rd_ready_i = 1'b0;
   endtask

   task automatic rd_at(input logic [7:0] a, output logic [7:0] v);
      set_addr(a);
      rd(1'b0, v);
   endtask

   initial begin
      #1_000_000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] exp_pos [7];
      exp_pos = '{8'h71, 8'h5A, 8'h3C, 8'h0B, 8'h92, 8'hE4, 8'h6D};

      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_valid after reset", int'(rd_valid_o), 0);
      chk("R1 ready after reset", int'(cmd_ready_o), 1);
      chk("R1 init low after reset", int'(sdram_init_o), 0);
      rd(1'b0, v);
      chk("R1 address 0 reads ID", v, 8'hA5);
      rd_at(8'h01, v); chk("R1 scratch reset", v, 0);
      rd_at(8'h02, v); chk("R1 mode reset", v, 0);
      // R1 latched nibble cleared: commit high nibble only
      set_addr(8'h01); send(8'h37);
      rd(1'b0, v); chk("R1 data nibble cleared", v, 8'h70);

      // R6 exhaustive scratch sweep
      for (int d = 0; d < 256; d++) begin
         wr(8'h01, 8'(d));
         rd(1'b0, v);
         chk("R6 scratch echo", v, d);
      end

      // R3 data-low alone does not write; commit combines nibbles
      wr(8'h01, 8'h3C);
      send(8'h2F);
      rd(1'b0, v); chk("R3 data-low no write", v, 8'h3C);
      send(8'h3A);
      rd(1'b0, v); chk("R3 commit combines", v, 8'hAF);

      // R2 nibble-wise address: change only the high half
      set_addr(8'h01);
      send(8'h11);
      rd(1'b0, v); chk("R2 high nibble to 0x11", v, exp_pos[1]);
      send(8'h05);
      rd(1'b0, v); chk("R2 low nibble to 0x15", v, exp_pos[5]);
      send(8'h10);
      rd(1'b0, v); chk("R2 high nibble to 0x05", v, 0);

      // R8 position block with increment; R5 increment step
      set_addr(8'h10);
      for (int i = 0; i < 7; i++) begin
         rd(1'b1, v);
         chk("R8 position byte order", v, exp_pos[i]);
      end
      // R12 unmapped 0x17 reached by increment
      rd(1'b1, v); chk("R12 unmapped reads zero", v, 0);

      // R5 wrap from 0x1F to 0x10, no carry
      set_addr(8'h1F);
      rd(1'b1, v); chk("R5 read at 0x1F", v, 0);
      rd(1'b1, v); chk("R5 wrap to 0x10", v, exp_pos[0]);
      rd(1'b0, v); chk("R5 step to 0x11", v, exp_pos[1]);
      rd(1'b0, v); chk("R5 plain read keeps address", v, exp_pos[1]);
      // wrap in block 0: 0x0F -> 0x00 (ID)
      set_addr(8'h0F);
      rd(1'b1, v);
      rd(1'b0, v); chk("R5 wrap to 0x00", v, 8'hA5);

      // R7 writes to read-only ignored
      wr(8'h00, 8'h00);
      rd(1'b0, v); chk("R7 ID unchanged", v, 8'hA5);
      wr(8'h13, 8'hFF);
      rd(1'b0, v); chk("R7 position unchanged", v, exp_pos[3]);

      // R9 init pulse and mode readback
      pulses = 0;
      wr(8'h02, 8'h85);
      repeat (4) @(negedge clk);
      chk("R9 one pulse", pulses, 1);
      rd(1'b0, v); chk("R9 mode bit0 cleared", v, 8'h84);
      pulses = 0;
      wr(8'h02, 8'h5A);
      repeat (4) @(negedge clk);
      chk("R9 no pulse with bit0 clear", pulses, 0);
      rd(1'b0, v); chk("R9 mode readback", v, 8'h5A);

      // R10 stall while result pending
      set_addr(8'h01);
      send(8'h40);
      @(negedge clk);
      chk("R10 valid pending", int'(rd_valid_o), 1);
      chk("R10 ready low", int'(cmd_ready_o), 0);
      cmd_byte_i = 8'h0F; cmd_valid_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 still not ready", int'(cmd_ready_o), 0);
      chk("R4 held byte", rd_byte_o, 8'hAF);
      cmd_valid_i = 1'b0;
      rd_ready_i = 1'b1;
      @(posedge clk); #1 rd_ready_i = 1'b0;
      rd(1'b0, v); chk("R10 stalled command not taken", v, 8'hAF);

      // R11 unused opcodes
      for (int op = 6; op < 16; op++) begin
         send({4'(op), 4'h3});
         @(negedge clk);
         chk("R11 no output", int'(rd_valid_o), 0);
      end
      rd(1'b0, v); chk("R11 state unchanged", v, 8'hAF);
      chk("R11 no pulse", pulses, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule